// File: doc/BRIEF.md
# Vector Register Group Micro-op Expander

This block sits between vector instruction decode and a single-register-wide execution pipe. It takes one decoded vector arithmetic instruction at a time. The instruction holds an operation code and three 5-bit register indices: a destination and two sources. Each index names the lowest register of a group. The group size comes from a separately loaded vector type configuration.

Before an instruction is expanded, all three operand indices are checked for alignment to the group size. A legal instruction becomes an ordered run of single-register micro-operations, one per register in the group, sent over a valid/ready handshake. An illegal instruction produces no micro-operations and raises a one-cycle illegal flag instead.

The block also reports the maximum element count for the loaded configuration. This is the vector length in bits divided by the element width, multiplied by the group size.

Top module: `vgroup_expander`

## Requirements
- R1: Group-size code `cfg_lmul` maps 3'b000, 3'b001, 3'b010 and 3'b011 to 1, 2, 4 and 8 registers. Codes 3'b100 to 3'b111 mark the configuration illegal, and every instruction accepted under such a configuration is rejected. A configuration written with `cfg_valid` applies from the next cycle onward.
- R2: An instruction is legal only if the low log2(size) bits of `in_vd`, `in_vs1` and `in_vs2` are all zero. The same indices can be legal at one group size and illegal at another.
- R3: A rejected instruction produces no micro-operation. `illegal` is high for exactly the one cycle after the instruction is accepted.
- R4: A legal instruction of group size N produces N micro-operations, for i = 0 to N-1 in increasing order. Step i carries destination vd+i, sources vs1+i and vs2+i, and the unchanged operation code.
- R5: `uop_last` is high on step N-1 only. The cycle after that step is taken, `uop_valid` is low.
- R6: While `uop_valid` is high and `uop_ready` is low, every micro-operation output holds its value.
- R7: `in_ready` is low from the cycle after a legal instruction is accepted until the cycle after its last micro-operation is taken.
- R8: `vlmax` equals VLEN / SEW × group size. The SEW code `cfg_sew` maps 2'b00, 2'b01, 2'b10 and 2'b11 to 8, 16, 32 and 64 bits. `vlmax` is 0 while the group-size code is illegal.
- R9: A configuration written while an expansion is in progress does not change the count or indices of that expansion.
- R10: After reset, the configuration is size 1 with SEW 8. `uop_valid` and `illegal` are low, `in_ready` is high, and `vlmax` is VLEN/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Load a new vector type configuration |
| cfg_lmul | input | 3 | Group-size code |
| cfg_sew | input | 2 | Element-width code |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | OPW | Operation code |
| in_vd | input | IDXW | Destination group base index |
| in_vs1 | input | IDXW | First source group base index |
| in_vs2 | input | IDXW | Second source group base index |
| uop_valid | output | 1 | Micro-operation offered |
| uop_ready | input | 1 | Micro-operation taken |
| uop_op | output | OPW | Operation code of the micro-operation |
| uop_vd | output | IDXW | Destination register |
| uop_vs1 | output | IDXW | First source register |
| uop_vs2 | output | IDXW | Second source register |
| uop_last | output | 1 | Final step of the group |
| illegal | output | 1 | Instruction rejected |
| vlmax | output | clog2(VLEN)+1 | Maximum element count |

## Verification
The assertions assume that `uop_ready` is driven from a clean register and never goes unknown. They also assume reset is held long enough for the configuration registers to settle. Index arithmetic is expected not to run past the register file, which holds for any aligned base. The stimulus drives every input on the falling edge and keeps `uop_ready` defined at all times. It writes configuration only through `cfg_valid`, so the assumptions on the handshake and on the configuration hold throughout.

// File: rtl/vgroup_expander.sv
module vgroup_expander #(
  parameter int VLEN = 128,
  parameter int IDXW = 5,
  parameter int OPW  = 6,
  localparam int VW  = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [2:0]      cfg_lmul,
  input  logic [1:0]      cfg_sew,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic [IDXW-1:0] in_vd,
  input  logic [IDXW-1:0] in_vs1,
  input  logic [IDXW-1:0] in_vs2,
  output logic            uop_valid,
  input  logic            uop_ready,
  output logic [OPW-1:0]  uop_op,
  output logic [IDXW-1:0] uop_vd,
  output logic [IDXW-1:0] uop_vs1,
  output logic [IDXW-1:0] uop_vs2,
  output logic            uop_last,
  output logic            illegal,
  output logic [VW-1:0]   vlmax
);

  localparam logic [VW-1:0] VBASE = VW'(VLEN / 8);

  logic [2:0]      lmul_q;
  logic [1:0]      sew_q;
  logic            busy;
  logic [2:0]      step, last_step;
  logic [OPW-1:0]  op_q;
  logic [IDXW-1:0] vd_q, vs1_q, vs2_q;
  logic            illegal_q;

  logic            cfg_ok;
  logic [IDXW-1:0] amask;
  logic            aligned;
  logic            accept;
  logic            fire;

  assign cfg_ok  = ~lmul_q[2];
  assign amask   = IDXW'((4'd1 << lmul_q[1:0]) - 4'd1);
  assign aligned = ((in_vd | in_vs1 | in_vs2) & amask) == '0;
  assign accept  = in_valid && in_ready;
  assign fire    = uop_valid && uop_ready;

  assign in_ready  = !busy;
  assign uop_valid = busy;
  assign uop_op    = op_q;
  assign uop_vd    = vd_q  + IDXW'(step);
  assign uop_vs1   = vs1_q + IDXW'(step);
  assign uop_vs2   = vs2_q + IDXW'(step);
  assign uop_last  = busy && (step == last_step);
  assign illegal   = illegal_q;
  assign vlmax     = cfg_ok ? ((VBASE >> sew_q) << lmul_q[1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmul_q <= 3'b000;
      sew_q  <= 2'b00;
    end else if (cfg_valid) begin
      lmul_q <= cfg_lmul;
      sew_q  <= cfg_sew;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      last_step <= '0;
      op_q      <= '0;
      vd_q      <= '0;
      vs1_q     <= '0;
      vs2_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      if (accept) begin
        if (cfg_ok && aligned) begin
          busy      <= 1'b1;
          step      <= '0;
          last_step <= 3'((4'd1 << lmul_q[1:0]) - 4'd1);
          op_q      <= in_op;
          vd_q      <= in_vd;
          vs1_q     <= in_vs1;
          vs2_q     <= in_vs2;
        end else begin
          illegal_q <= 1'b1;
        end
      end else if (fire) begin
        if (step == last_step) busy <= 1'b0;
        else step <= step + 3'd1;
      end
    end
  end

  assert_no_uop_on_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !uop_valid);

  assert_step_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !uop_last) |=> (uop_valid && uop_vd == $past(uop_vd) + IDXW'(1)
                             && uop_vs1 == $past(uop_vs1) + IDXW'(1)
                             && uop_vs2 == $past(uop_vs2) + IDXW'(1)
                             && uop_op == $past(uop_op)));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && uop_last) |=> !uop_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_vd) && $stable(uop_vs1)
                                   && $stable(uop_vs2) && $stable(uop_op) && $stable(uop_last)));

  assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !in_ready);

  assert_vlmax_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vlmax <= VW'(VLEN));

endmodule

// File: tb/vgroup_expander_bench.sv
module vgroup_expander_bench;
  localparam int VLEN = 128;
  localparam int IDXW = 5;
  localparam int OPW  = 6;
  localparam int VW   = $clog2(VLEN) + 1;
  localparam int NV   = 11;

  // columns: lmul code, sew code, vd, vs1, vs2
  localparam int TL [NV] = '{0, 1, 2, 3, 3, 1, 2, 2, 3, 0, 3};
  localparam int TS [NV] = '{0, 1, 2, 3, 0, 3, 1, 0, 2, 3, 1};
  localparam int TD [NV] = '{4, 4, 4, 4, 16, 5, 8, 28, 0, 31, 24};
  localparam int T1 [NV] = '{0, 0, 0, 0, 8, 6, 2, 24, 8, 17, 0};
  localparam int T2 [NV] = '{12, 12, 12, 12, 24, 0, 16, 20, 9, 3, 16};

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0;
  logic [2:0] cfg_lmul = 0;
  logic [1:0] cfg_sew = 0;
  logic in_valid = 0, uop_ready = 1;
  logic [OPW-1:0] in_op = 0;
  logic [IDXW-1:0] in_vd = 0, in_vs1 = 0, in_vs2 = 0;
  logic in_ready, uop_valid, uop_last, illegal;
  logic [OPW-1:0] uop_op;
  logic [IDXW-1:0] uop_vd, uop_vs1, uop_vs2;
  logic [VW-1:0] vlmax;
  int total = 0, failed = 0;

  always #2 clk = ~clk;

  vgroup_expander #(.VLEN(VLEN), .IDXW(IDXW), .OPW(OPW)) u_vgroup_expander (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_lmul(cfg_lmul), .cfg_sew(cfg_sew),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_vd(in_vd),
    .in_vs1(in_vs1), .in_vs2(in_vs2), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_op(uop_op), .uop_vd(uop_vd), .uop_vs1(uop_vs1), .uop_vs2(uop_vs2),
    .uop_last(uop_last), .illegal(illegal), .vlmax(vlmax));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int l, input int s);
    @(negedge clk);
    cfg_valid = 1; cfg_lmul = 3'(l); cfg_sew = 2'(s);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic issue(input int op, input int vd, input int v1, input int v2);
    @(negedge clk);
    check(in_ready == 1, "R7 ready before issue", int'(in_ready), 1);
    in_valid = 1; in_op = OPW'(op); in_vd = IDXW'(vd); in_vs1 = IDXW'(v1); in_vs2 = IDXW'(v2);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_reject(input string req);
    check(illegal == 1, req, int'(illegal), 1);
    check(uop_valid == 0, "R3 no uop on reject", int'(uop_valid), 0);
    @(negedge clk);
    check(illegal == 0, "R3 illegal one cycle", int'(illegal), 0);
  endtask

  task automatic expect_run(input int op, input int n, input int vd, input int v1, input int v2);
    for (int i = 0; i < n; i++) begin
      check(uop_valid == 1 && illegal == 0, "R4 uop valid", int'(uop_valid), 1);
      check(uop_vd == IDXW'(vd + i) && uop_vs1 == IDXW'(v1 + i) && uop_vs2 == IDXW'(v2 + i),
            "R4 step indices", int'(uop_vd), vd + i);
      check(uop_op == OPW'(op), "R4 op unchanged", int'(uop_op), op);
      check(uop_last == (i == n - 1), "R5 last flag", int'(uop_last), int'(i == n - 1));
      check(in_ready == 0, "R7 ready low in expansion", int'(in_ready), 0);
      @(negedge clk);
    end
    check(uop_valid == 0, "R5 idle after last", int'(uop_valid), 0);
    check(in_ready == 1, "R7 ready after last", int'(in_ready), 1);
  endtask

  initial begin
    #(4 * 150000);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(uop_valid == 0 && illegal == 0, "R10 reset outputs", int'(uop_valid), 0);
    check(in_ready == 1, "R10 reset ready", int'(in_ready), 1);
    check(vlmax == VW'(VLEN / 8), "R10 reset vlmax", int'(vlmax), VLEN / 8);
    rst_n = 1;
    @(negedge clk);
    issue(1, 7, 3, 30);
    expect_run(1, 1, 7, 3, 30);

    for (int k = 0; k < NV; k++) begin
      int n, m;
      bit ok;
      n = 1 << TL[k];
      m = n - 1;
      ok = ((TD[k] & m) == 0) && ((T1[k] & m) == 0) && ((T2[k] & m) == 0);
      set_cfg(TL[k], TS[k]);
      check(vlmax == VW'((VLEN / (8 << TS[k])) * n), "R8 vlmax", int'(vlmax), (VLEN / (8 << TS[k])) * n);
      issue(k + 7, TD[k], T1[k], T2[k]);
      if (ok) expect_run(k + 7, n, TD[k], T1[k], T2[k]);
      else expect_reject("R2 misaligned rejected");
    end

    // R6 and R9: hold under backpressure, config change mid-expansion
    set_cfg(2, 0);
    uop_ready = 0;
    issue(33, 12, 20, 4);
    for (int c = 0; c < 3; c++) begin
      check(uop_valid == 1 && uop_vd == 12 && uop_vs1 == 20 && uop_vs2 == 4 && uop_last == 0,
            "R6 held under backpressure", int'(uop_vd), 12);
      check(in_ready == 0, "R7 ready low while stalled", int'(in_ready), 0);
      if (c == 0) begin cfg_valid = 1; cfg_lmul = 3'd3; end
      @(negedge clk);
      cfg_valid = 0;
    end
    uop_ready = 1;
    expect_run(33, 4, 12, 20, 4);
    check(vlmax == VW'(VLEN), "R9 new config applied", int'(vlmax), VLEN);

    // R1: illegal group-size codes
    set_cfg(4, 0);
    check(vlmax == 0, "R8 vlmax zero illegal cfg", int'(vlmax), 0);
    issue(2, 0, 0, 0);
    expect_reject("R1 illegal cfg rejects");
    set_cfg(7, 1);
    issue(3, 8, 16, 24);
    expect_reject("R1 illegal cfg code 7 rejects");
    // back-to-back rejects then recovery
    set_cfg(1, 0);
    issue(4, 1, 0, 0);
    expect_reject("R2 odd vd at size 2");
    issue(5, 2, 4, 6);
    expect_run(5, 2, 2, 4, 6);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule